// File: doc/BRIEF.md
# Prefix-Code Bit Packer

This block turns a stream of symbol numbers into a dense stream of 64-bit words. Each symbol number selects an entry in a small internal code table, written beforehand through a table write port. An entry holds a code value and a code length. Codes are laid down least-significant bit first at a running bit position. When a word fills, it is handed out, and the bits of the code that did not fit start the next word at bit 0.

A stream begins at a programmable bit position below 64, so that a new stream can continue a word that was partly filled earlier. A flush request closes the stream. If bits are pending, the partial word goes out marked as the last word, together with the bit index where its zero padding begins. The output uses a valid/ready handshake. While a word waits in the output register, the block accepts no symbol and no flush.

Top module: `prefix_packer`

## Requirements
- R1: While reset is asserted and after its release, `out_valid` is 0 and `in_ready` is 1.
- R2: A cycle with `tbl_we` high stores `tbl_code` and `tbl_len` at entry `tbl_sel`. The supported lengths are 1 to 64. Code bits at and above the stored length never reach the output.
- R3: A symbol accepted first after reset or after a flush places its code starting at bit `start_pos`. Bit k of each code lands at position p+k, where p is the sum of the earlier lengths in the stream. Bit 0 of the word is the first position.
- R4: When the position reaches 64 or more, the filled word is emitted with `out_last`=0 and `out_pad`=0. The code bits past bit 63 begin the next word at bit 0, and 64 is subtracted from the position.
- R5: A code that ends exactly at bit 63 emits its word and leaves nothing pending.
- R6: An accepted flush with pending bits emits the partial word with `out_last`=1. `out_pad` equals the next free bit index (1 to 63), and all word bits at and above it are 0.
- R7: An accepted flush with no pending bits emits no word. Either kind of flush makes the next symbol start at `start_pos` again.
- R8: While `out_valid` is high, `in_ready` is low, and the output fields hold until `out_ready` is high.
- R9: When `sym_valid` and `flush` are both high in an accepting cycle, the block takes the symbol. The flush is taken in a later accepting cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table write enable |
| tbl_sel | input | SYM_W | Table entry to write |
| tbl_code | input | WORD_W | Code value to store |
| tbl_len | input | LEN_W | Code length to store (1 to 64) |
| start_pos | input | POS_W | Bit position at which a new stream begins |
| sym_valid | input | 1 | Symbol number is offered |
| sym_idx | input | SYM_W | Symbol number |
| flush | input | 1 | Request to close the stream |
| in_ready | output | 1 | Symbol or flush can be taken this cycle |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Consumer takes the output word |
| out_word | output | WORD_W | Packed word |
| out_last | output | 1 | Word was produced by a flush |
| out_pad | output | POS_W | First zero-padding bit of a last word, else 0 |

## Verification
The assertions assume that every table entry in use holds a length from 1 to 64. They also assume that `start_pos` does not change while a stream is open, because the padding and placement properties rely on a position that stays below 64. The bench keeps to both: it writes only lengths in that range, and it changes `start_pos` only after a flush. The sweeps cover every length from 1 to 64 against several start positions. They include the case of a code ending exactly at bit 63.

// File: rtl/prefix_packer.sv
module prefix_packer #(
  parameter int WORD_W = 64,
  parameter int SYM_W  = 4,
  localparam int POS_W = $clog2(WORD_W),
  localparam int LEN_W = $clog2(WORD_W + 1),
  localparam int DEPTH = 1 << SYM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [SYM_W-1:0]  tbl_sel,
  input  logic [WORD_W-1:0] tbl_code,
  input  logic [LEN_W-1:0]  tbl_len,
  input  logic [POS_W-1:0]  start_pos,
  input  logic              sym_valid,
  input  logic [SYM_W-1:0]  sym_idx,
  input  logic              flush,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              out_last,
  output logic [POS_W-1:0]  out_pad
);

  logic [WORD_W-1:0] code_mem [DEPTH];
  logic [LEN_W-1:0]  len_mem  [DEPTH];

  always_ff @(posedge clk) begin
    if (tbl_we) begin
      code_mem[tbl_sel] <= tbl_code;
      len_mem[tbl_sel]  <= tbl_len;
    end
  end

  logic [WORD_W-1:0] acc;
  logic [POS_W-1:0]  pos;
  logic              fresh;

  logic [LEN_W-1:0]    cur_len;
  logic [WORD_W-1:0]   cur_mask;
  logic [POS_W-1:0]    base;
  logic [2*WORD_W-1:0] placed;
  logic [WORD_W-1:0]   merged;
  logic [LEN_W:0]      next_pos;
  logic                wrap, take_sym, take_flush, pending;

  assign cur_len  = len_mem[sym_idx];
  assign cur_mask = (cur_len >= LEN_W'(WORD_W)) ? '1 : ((WORD_W'(1) << cur_len) - WORD_W'(1));
  assign base     = fresh ? start_pos : pos;
  assign placed   = {{WORD_W{1'b0}}, code_mem[sym_idx] & cur_mask} << base;
  assign merged   = (fresh ? '0 : acc) | placed[WORD_W-1:0];
  assign next_pos = (LEN_W+1)'(base) + (LEN_W+1)'(cur_len);
  assign wrap     = next_pos >= (LEN_W+1)'(WORD_W);

  assign in_ready   = !out_valid;
  assign take_sym   = sym_valid && in_ready;
  assign take_flush = flush && in_ready && !sym_valid;
  assign pending    = !fresh && (pos != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      pos       <= '0;
      fresh     <= 1'b1;
      out_valid <= 1'b0;
      out_word  <= '0;
      out_last  <= 1'b0;
      out_pad   <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (take_sym) begin
        fresh <= 1'b0;
        if (wrap) begin
          out_valid <= 1'b1;
          out_word  <= merged;
          out_last  <= 1'b0;
          out_pad   <= '0;
          acc       <= placed[2*WORD_W-1:WORD_W];
          pos       <= POS_W'(next_pos - (LEN_W+1)'(WORD_W));
        end else begin
          acc <= merged;
          pos <= POS_W'(next_pos);
        end
      end else if (take_flush) begin
        fresh <= 1'b1;
        acc   <= '0;
        pos   <= '0;
        if (pending) begin
          out_valid <= 1'b1;
          out_word  <= acc;
          out_last  <= 1'b1;
          out_pad   <= pos;
        end
      end
    end
  end

endmodule

// File: rtl/prefix_packer_chk.sv
module prefix_packer_chk #(
  parameter int WORD_W = 64,
  localparam int POS_W = $clog2(WORD_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sym_valid,
  input logic              flush,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_word,
  input logic              out_last,
  input logic [POS_W-1:0]  out_pad
);

  // R8
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_last) && $stable(out_pad));

  // R4
  full_word_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |-> out_pad == '0);

  // R6
  last_word_padding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last |-> out_pad != '0 && (out_word >> out_pad) == '0);

  // R9
  word_needs_intake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_ready && (sym_valid || flush)));

endmodule

bind prefix_packer prefix_packer_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/prefix_packer_bench.sv
module prefix_packer_bench;
  localparam int WORD_W = 64;
  localparam int SYM_W  = 3;
  localparam int POS_W  = 6;
  localparam int LEN_W  = 7;
  localparam int NSYM   = 1 << SYM_W;

  logic clk = 0, rst_n = 0;
  logic tbl_we = 0;
  logic [SYM_W-1:0] tbl_sel = '0;
  logic [WORD_W-1:0] tbl_code = '0;
  logic [LEN_W-1:0] tbl_len = '0;
  logic [POS_W-1:0] start_pos = '0;
  logic sym_valid = 0, flush = 0, out_ready = 1;
  logic [SYM_W-1:0] sym_idx = '0;
  logic in_ready, out_valid, out_last;
  logic [WORD_W-1:0] out_word;
  logic [POS_W-1:0] out_pad;

  prefix_packer #(.WORD_W(WORD_W), .SYM_W(SYM_W)) u_prefix_packer (.*);

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  logic [WORD_W-1:0] tcode [NSYM];
  int tlen [NSYM];
  logic [WORD_W-1:0] exp_word [2048];
  logic exp_last [2048];
  int exp_pad [2048];
  int exp_wp = 0, got_rp = 0;
  logic [WORD_W-1:0] macc = '0;
  int mpos = 0;
  bit mfresh = 1;

  task automatic check(bit ok, string tag, logic [WORD_W-1:0] act, logic [WORD_W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(logic [WORD_W-1:0] w, logic l, int p);
    exp_word[exp_wp] = w; exp_last[exp_wp] = l; exp_pad[exp_wp] = p; exp_wp++;
  endtask

  task automatic model_sym(int idx);
    if (mfresh) begin mpos = int'(start_pos); macc = '0; mfresh = 0; end
    for (int k = 0; k < tlen[idx]; k++) begin
      macc[mpos] = tcode[idx][k];
      mpos++;
      if (mpos == WORD_W) begin push(macc, 1'b0, 0); macc = '0; mpos = 0; end
    end
  endtask

  task automatic model_flush();
    if (!mfresh && mpos != 0) push(macc, 1'b1, mpos);
    mfresh = 1; mpos = 0; macc = '0;
  endtask

  task automatic write_tbl(int idx, logic [WORD_W-1:0] c, int l);
    tcode[idx] = c; tlen[idx] = l;
    tbl_we = 1; tbl_sel = SYM_W'(idx); tbl_code = c; tbl_len = LEN_W'(l);
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic send_sym(int idx);
    model_sym(idx);
    sym_idx = SYM_W'(idx); sym_valid = 1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    sym_valid = 0;
  endtask

  task automatic send_flush();
    model_flush();
    flush = 1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    flush = 0;
  endtask

  task automatic send_both(int idx);
    model_sym(idx);
    model_flush();
    sym_idx = SYM_W'(idx); sym_valid = 1; flush = 1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    sym_valid = 0;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    flush = 0;
  endtask

  task automatic drain(string tag);
    for (int i = 0; i < 400 && got_rp != exp_wp; i++) @(negedge clk);
    repeat (6) @(negedge clk);
    check(got_rp == exp_wp, tag, 64'(got_rp), 64'(exp_wp));
  endtask

  always @(posedge clk) begin
    #2;
    out_ready = ($urandom_range(3) != 0);
  end

  bit hold_pend = 0;
  logic [WORD_W-1:0] hold_word;
  logic hold_last;
  logic [POS_W-1:0] hold_pad;

  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend)
        check(out_valid && !in_ready && out_word == hold_word && out_last == hold_last && out_pad == hold_pad,
              "R8 output held under back-pressure", out_word, hold_word);
      hold_pend = out_valid && !out_ready;
      hold_word = out_word; hold_last = out_last; hold_pad = out_pad;
      if (out_valid && out_ready) begin
        if (got_rp >= exp_wp) begin
          check(0, "R7 unexpected word", out_word, '0);
        end else begin
          check(out_word == exp_word[got_rp], "R2/R3/R4/R5 word content", out_word, exp_word[got_rp]);
          check(out_last == exp_last[got_rp], "R4/R6 last flag", 64'(out_last), 64'(exp_last[got_rp]));
          check(int'(out_pad) == exp_pad[got_rp], "R4/R6 pad index", 64'(out_pad), 64'(exp_pad[got_rp]));
        end
        got_rp++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(!out_valid && in_ready, "R1 state during reset", {in_ready, out_valid}, 2'b10);
    rst_n = 1;
    @(negedge clk);
    check(!out_valid && in_ready, "R1 state after reset", {in_ready, out_valid}, 2'b10);

    // R2: random codes with junk above each length
    for (int i = 0; i < NSYM; i++)
      write_tbl(i, {$urandom, $urandom}, (i == 0) ? 64 : int'($urandom_range(64, 1)));
    foreach (tcode[s]) begin end
    for (int s = 0; s < 6; s++) begin
      int sp [6] = '{0, 1, 5, 31, 62, 63};
      start_pos = POS_W'(sp[s]);
      for (int n = 0; n < 50; n++) send_sym(int'($urandom_range(NSYM - 1)));
      send_flush();
      drain("R3 random stream word count");
    end

    // R5 and R4 across every length
    for (int l = 1; l <= 64; l++) begin
      write_tbl(0, {$urandom, $urandom}, l);
      write_tbl(1, {$urandom, $urandom}, 65 - l);
      start_pos = POS_W'((l * 7) % 64);
      send_sym(0); send_sym(1); send_sym(0); send_sym(1); send_sym(0);
      send_flush();
      drain("R4 length sweep word count");
    end

    // R5: exact fill from position 0
    write_tbl(2, '1, 64);
    write_tbl(3, 64'h5, 32);
    start_pos = '0;
    send_sym(2); send_sym(3); send_sym(3);
    send_flush();
    drain("R5 exact word boundary");

    // R7: flush with nothing pending, start_pos reapplied
    start_pos = 6'd17;
    send_flush();
    send_flush();
    drain("R7 empty flush emits nothing");
    send_sym(3); send_flush();
    drain("R7 restart at start_pos");

    // R9
    start_pos = 6'd40;
    send_both(3);
    drain("R9 symbol before flush");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule